// File: doc/BRIEF.md
# Nibble-Wide Synchronous Debug Bus Driver

This block is the pin-level engine for a four-bit synchronous debug port. The port has a clock that this block generates, a sync strobe and a four-bit data bus that can be driven or released. A higher-level controller sends it one command at a time on a valid/ready stream. A write command puts one nibble and a sync level on the lines. A read command releases the data lines, drives the sync level and samples one nibble, which goes back on a result stream. Every command produces exactly one clock pulse. The controller never handles the debug clock directly.

The debug clock comes from the system clock. The low phase and the high phase each last a programmable number of system cycles. That number is captured when a command is accepted, so a slow or fast port rate can be chosen at run time. The port's reset and mode pins are not part of the transfer path. They are registered copies of two static host inputs.

Top module: `nibble_bus_driver`

## Requirements
- R1: After reset the data lines are released (`dbgDataOe`=0), `dbgSync`=1, `dbgClk`=1, `rspValid`=0, `cmdReady`=1, `dbgResetN`=0 and `dbgMode`=0.
- R2: A command is accepted on a clock edge where `cmdValid` and `cmdReady` are both 1. From the next cycle, `dbgClk` is low for exactly H cycles, then high for exactly H cycles, and then the block is idle with `dbgClk` still high. H is `cfgHalfPeriod`, and a value of 0 is treated as 1. Each command gives exactly one rising edge of `dbgClk`.
- R3: On a write (`cmdIsRead`=0), from the first low cycle onward: `dbgDataOut` equals `cmdData`, `dbgDataOe`=1, and `dbgSync` equals `cmdSync`. These values stay stable through the whole pulse, so data is set up H cycles before the rising edge.
- R4: On a read (`cmdIsRead`=1), from the first low cycle onward: `dbgDataOe`=0 and `dbgSync` equals `cmdSync`. `rspData[3:0]` is the value that `dbgDataIn[3:0]` had at the system edge where `dbgClk` rises. Later changes of `dbgDataIn` have no effect on it.
- R5: After a read's high phase, `rspValid` rises. It stays high with `rspData` stable until a cycle with `rspReady`=1. While `rspValid` is 1, `cmdReady` is 0 and no further clock pulse occurs.
- R6: `cmdReady` is 0 from acceptance until the end of the high phase.
- R7: A change of `cfgHalfPeriod` during a transfer does not alter that transfer's phase lengths.
- R8: `dbgResetN` and `dbgMode` follow `ctlResetN` and `ctlMode` one cycle later, independent of transfers.
- R9: A write never raises `rspValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgHalfPeriod | input | HP_W | Debug clock half-period in system cycles (0 acts as 1) |
| cmdValid | input | 1 | Command valid |
| cmdReady | output | 1 | Command accepted when high with cmdValid |
| cmdIsRead | input | 1 | 1 = sample a nibble, 0 = drive a nibble |
| cmdSync | input | 1 | Sync level for this transfer |
| cmdData | input | 4 | Nibble to drive on a write |
| rspValid | output | 1 | Read result valid |
| rspReady | input | 1 | Read result consumed |
| rspData | output | 4 | Sampled nibble |
| ctlResetN | input | 1 | Host setting for the port reset pin |
| ctlMode | input | 1 | Host setting for the port mode pin |
| dbgResetN | output | 1 | Port reset pin, active low |
| dbgMode | output | 1 | Port mode pin |
| dbgClk | output | 1 | Generated debug clock |
| dbgSync | output | 1 | Sync strobe |
| dbgDataOut | output | 4 | Data driven to the pad |
| dbgDataOe | output | 1 | Pad output enable |
| dbgDataIn | input | 4 | Data from the pad |

## Verification
A read result can be consumed in the same cycle in which the controller presents the next command. The bench provokes this by holding a result with `rspReady` low and `cmdValid` high for several cycles. It then raises `rspReady` while keeping `cmdValid` asserted. The check requires that the result clears on that edge, that `dbgClk` is still high in the following cycle because the command was not yet taken, and that the clock falls one cycle later. A second overlap is a half-period change that lands mid-transfer. It is judged by the low-phase length, which must keep the value captured at acceptance.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } nbdState_t;

  typedef struct packed {
    logic loadCmd;   // latch sync/data/oe, drop the debug clock
    logic riseClk;   // raise the debug clock
    logic capture;   // sample the pad into the result register
  } nbdStrobes_t;
endpackage

// File: rtl/nbd_ctrl.sv
module nbd_ctrl
  import nbd_pkg::*;
#(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [HP_W-1:0] cfgHalfPeriod,
  input  logic            cmdValid,
  input  logic            cmdIsRead,
  output logic            cmdReady,
  input  logic            rspReady,
  output logic            rspValid,
  output nbdStrobes_t     strb
);
  nbdState_t       state;
  logic [HP_W-1:0] cnt;
  logic [HP_W-1:0] hpHold;
  logic            isRead;
  logic [HP_W-1:0] effHp;
  logic            accept;
  logic            cntZero;

  assign effHp   = (cfgHalfPeriod == '0) ? HP_W'(1) : cfgHalfPeriod;
  assign cmdReady = (state == ST_IDLE) && !rspValid;
  assign accept  = cmdValid && cmdReady;
  assign cntZero = (cnt == '0);

  always_comb begin
    strb         = '0;
    strb.loadCmd = accept;
    strb.riseClk = (state == ST_LOW) && cntZero;
    strb.capture = (state == ST_LOW) && cntZero && isRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      hpHold   <= HP_W'(1);
      isRead   <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rspValid && rspReady) rspValid <= 1'b0;
          if (accept) begin
            state  <= ST_LOW;
            cnt    <= effHp - HP_W'(1);
            hpHold <= effHp;
            isRead <= cmdIsRead;
          end
        end
        ST_LOW: begin
          if (cntZero) begin
            state <= ST_HIGH;
            cnt   <= hpHold - HP_W'(1);
          end else begin
            cnt <= cnt - HP_W'(1);
          end
        end
        ST_HIGH: begin
          if (cntZero) begin
            state <= ST_IDLE;
            if (isRead) rspValid <= 1'b1;
          end else begin
            cnt <= cnt - HP_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbd_datapath.sv
module nbd_datapath
  import nbd_pkg::*;
#(
  parameter int DATA_W = NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  nbdStrobes_t       strb,
  input  logic              cmdIsRead,
  input  logic              cmdSync,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              ctlResetN,
  input  logic              ctlMode,
  input  logic [DATA_W-1:0] dbgDataIn,
  output logic [DATA_W-1:0] rspData,
  output logic              dbgResetN,
  output logic              dbgMode,
  output logic              dbgClk,
  output logic              dbgSync,
  output logic [DATA_W-1:0] dbgDataOut,
  output logic              dbgDataOe
);
  // Output flops for the transfer lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgClk     <= 1'b1;
      dbgSync    <= 1'b1;
      dbgDataOut <= '0;
      dbgDataOe  <= 1'b0;
    end else begin
      if (strb.loadCmd) begin
        dbgClk    <= 1'b0;
        dbgSync   <= cmdSync;
        dbgDataOe <= !cmdIsRead;
        if (!cmdIsRead) dbgDataOut <= cmdData;
      end else if (strb.riseClk) begin
        dbgClk <= 1'b1;
      end
    end
  end

  // Input flop: samples the pad on the rising debug clock edge
  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else if (strb.capture) rspData <= dbgDataIn;
  end

  // Static control pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgResetN <= 1'b0;
      dbgMode   <= 1'b0;
    end else begin
      dbgResetN <= ctlResetN;
      dbgMode   <= ctlMode;
    end
  end
endmodule

// File: rtl/nibble_bus_driver.sv
module nibble_bus_driver
  import nbd_pkg::*;
#(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [HP_W-1:0] cfgHalfPeriod,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic            cmdIsRead,
  input  logic            cmdSync,
  input  logic [3:0]      cmdData,
  output logic            rspValid,
  input  logic            rspReady,
  output logic [3:0]      rspData,
  input  logic            ctlResetN,
  input  logic            ctlMode,
  output logic            dbgResetN,
  output logic            dbgMode,
  output logic            dbgClk,
  output logic            dbgSync,
  output logic [3:0]      dbgDataOut,
  output logic            dbgDataOe,
  input  logic [3:0]      dbgDataIn
);
  nbdStrobes_t strb;

  nbd_ctrl #(.HP_W(HP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgHalfPeriod(cfgHalfPeriod),
    .cmdValid(cmdValid), .cmdIsRead(cmdIsRead), .cmdReady(cmdReady),
    .rspReady(rspReady), .rspValid(rspValid), .strb(strb)
  );

  nbd_datapath #(.DATA_W(NIB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdIsRead(cmdIsRead), .cmdSync(cmdSync), .cmdData(cmdData),
    .ctlResetN(ctlResetN), .ctlMode(ctlMode), .dbgDataIn(dbgDataIn),
    .rspData(rspData), .dbgResetN(dbgResetN), .dbgMode(dbgMode),
    .dbgClk(dbgClk), .dbgSync(dbgSync), .dbgDataOut(dbgDataOut),
    .dbgDataOe(dbgDataOe)
  );
endmodule

// File: rtl/nbd_checker.sv
module nbd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic       cmdIsRead,
  input logic       rspValid,
  input logic       rspReady,
  input logic [3:0] rspData,
  input logic       ctlMode,
  input logic       dbgMode,
  input logic       dbgClk,
  input logic       dbgSync,
  input logic [3:0] dbgDataOut,
  input logic       dbgDataOe
);
  AST_ACCEPT_DROPS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !dbgClk); // R2

  AST_LOW_PHASE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!dbgClk && $past(!dbgClk)) |-> ($stable(dbgDataOut) && $stable(dbgSync) && $stable(dbgDataOe))); // R3

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !cmdIsRead) |=> dbgDataOe); // R3

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdIsRead) |=> !dbgDataOe); // R4

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData))); // R5

  AST_RSP_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!cmdReady && dbgClk)); // R5

  AST_BUSY_DURING_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !dbgClk |-> !cmdReady); // R6

  AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (dbgMode == $past(ctlMode))); // R8
endmodule

bind nibble_bus_driver nbd_checker u_nbdChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdIsRead(cmdIsRead), .rspValid(rspValid), .rspReady(rspReady),
  .rspData(rspData), .ctlMode(ctlMode), .dbgMode(dbgMode), .dbgClk(dbgClk),
  .dbgSync(dbgSync), .dbgDataOut(dbgDataOut), .dbgDataOe(dbgDataOe)
);

// File: tb/test_nibble_bus_driver.sv
module test_nibble_bus_driver;
  localparam int CLK_PERIOD = 10;
  localparam int HP_W = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [HP_W-1:0] cfgHalfPeriod = 8'd1;
  logic            cmdValid = 1'b0;
  logic            cmdReady;
  logic            cmdIsRead = 1'b0;
  logic            cmdSync = 1'b0;
  logic [3:0]      cmdData = 4'd0;
  logic            rspValid;
  logic            rspReady = 1'b0;
  logic [3:0]      rspData;
  logic            ctlResetN = 1'b0;
  logic            ctlMode = 1'b0;
  logic            dbgResetN, dbgMode, dbgClk, dbgSync, dbgDataOe;
  logic [3:0]      dbgDataOut;
  logic [3:0]      dbgDataIn = 4'd0;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_bus_driver #(.HP_W(HP_W)) i_nibble_bus_driver (
    .clk(clk), .rstN(rstN), .cfgHalfPeriod(cfgHalfPeriod),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdIsRead(cmdIsRead),
    .cmdSync(cmdSync), .cmdData(cmdData), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData), .ctlResetN(ctlResetN),
    .ctlMode(ctlMode), .dbgResetN(dbgResetN), .dbgMode(dbgMode),
    .dbgClk(dbgClk), .dbgSync(dbgSync), .dbgDataOut(dbgDataOut),
    .dbgDataOe(dbgDataOe), .dbgDataIn(dbgDataIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One transfer; cfgAfter >= 0 changes the half period right after acceptance
  task automatic runCmd(input bit isRd, input logic [3:0] d, input bit s,
                        input int h, input int cfgAfter);
    int effH;
    int lowCnt;
    int highCnt;
    int guard;
    effH = (h == 0) ? 1 : h;
    @(negedge clk);
    cfgHalfPeriod = HP_W'(h);
    cmdValid = 1'b1; cmdIsRead = isRd; cmdData = d; cmdSync = s;
    if (isRd) dbgDataIn = d;
    check(cmdReady == 1'b1, "R6 ready before accept", cmdReady, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdData = ~d;  // the held value must not follow the command inputs
    if (cfgAfter >= 0) cfgHalfPeriod = HP_W'(cfgAfter);
    check(dbgClk == 1'b0, "R2 clock low after accept", dbgClk, 0);
    check(dbgSync == s, "R3 R4 sync level", dbgSync, s);
    check(dbgDataOe == !isRd, "R3 R4 output enable", dbgDataOe, !isRd);
    if (!isRd) check(dbgDataOut == d, "R3 write data", dbgDataOut, d);
    lowCnt = 1;
    guard = 0;
    while (guard < 300) begin
      guard++;
      @(negedge clk);
      if (dbgClk) break;
      lowCnt++;
      check(cmdReady == 1'b0, "R6 busy in low phase", cmdReady, 0);
      if (!isRd) check(dbgDataOut == d && dbgDataOe, "R3 data held", dbgDataOut, d);
    end
    if (isRd) dbgDataIn = ~d;  // after the sampling edge, must not matter
    check(lowCnt == effH, (cfgAfter >= 0) ? "R7 low phase length kept" : "R2 low phase length",
          lowCnt, effH);
    highCnt = 1;
    guard = 0;
    while (guard < 300) begin
      guard++;
      check(dbgClk == 1'b1, "R2 single pulse, clock high", dbgClk, 1);
      @(negedge clk);
      if (cmdReady || rspValid) break;
      highCnt++;
    end
    check(highCnt == effH, "R2 high phase length", highCnt, effH);
    check(dbgClk == 1'b1, "R2 clock idles high", dbgClk, 1);
    if (isRd) begin
      check(rspValid == 1'b1, "R5 result valid", rspValid, 1);
      check(rspData == d, "R4 sampled nibble", rspData, d);
      check(cmdReady == 1'b0, "R5 no command while result pending", cmdReady, 0);
      rspReady = 1'b1;
      @(negedge clk);
      rspReady = 1'b0;
      check(rspValid == 1'b0, "R5 result consumed", rspValid, 0);
      check(cmdReady == 1'b1, "R5 ready after consume", cmdReady, 1);
    end else begin
      check(rspValid == 1'b0, "R9 write gives no result", rspValid, 0);
      check(dbgDataOut == d && dbgDataOe, "R3 data held after pulse", dbgDataOut, d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int hList[5];
    hList = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk);
    check(dbgDataOe == 1'b0, "R1 data released", dbgDataOe, 0);
    check(dbgSync == 1'b1, "R1 sync high", dbgSync, 1);
    check(dbgClk == 1'b1, "R1 clock high", dbgClk, 1);
    check(dbgResetN == 1'b0 && dbgMode == 1'b0, "R1 static pins", dbgResetN, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R1 no result", rspValid, 0);
    check(cmdReady == 1'b1, "R1 ready", cmdReady, 1);

    // R8: static pins
    ctlResetN = 1'b1; ctlMode = 1'b1;
    @(negedge clk);
    check(dbgResetN == 1'b1, "R8 reset pin follows", dbgResetN, 1);
    check(dbgMode == 1'b1, "R8 mode pin follows", dbgMode, 1);
    ctlMode = 1'b0;
    @(negedge clk);
    check(dbgMode == 1'b0 && dbgResetN == 1'b1, "R8 mode pin clears", dbgMode, 0);

    // Sweep half periods, nibbles and sync levels for writes and reads
    foreach (hList[k]) begin
      for (int d = 0; d < 16; d++) begin
        for (int s = 0; s < 2; s++) begin
          runCmd(1'b0, 4'(d), s[0], hList[k], -1);
          runCmd(1'b1, 4'(15 - d), s[0], hList[k], -1);
        end
      end
    end

    // R7: half period changed during a transfer
    runCmd(1'b0, 4'hA, 1'b0, 4, 1);
    runCmd(1'b1, 4'h6, 1'b1, 2, 7);

    // R5: result held, then consumed in the same cycle a command is offered
    runCmd(1'b0, 4'h3, 1'b1, 1, -1);
    @(negedge clk);
    cfgHalfPeriod = 8'd2;
    cmdValid = 1'b1; cmdIsRead = 1'b1; cmdSync = 1'b0; dbgDataIn = 4'h9;
    begin
      int guard;
      guard = 0;
      while (!rspValid && guard < 50) begin
        guard++;
        @(negedge clk);
        if (!rspValid) cmdValid = 1'b0;
      end
    end
    cmdValid = 1'b1; cmdIsRead = 1'b0; cmdData = 4'h5;
    repeat (3) begin
      @(negedge clk);
      check(rspValid == 1'b1 && rspData == 4'h9, "R5 result held while stalled", rspData, 9);
      check(dbgClk == 1'b1 && cmdReady == 1'b0, "R5 no pulse while stalled", dbgClk, 1);
    end
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    check(rspValid == 1'b0, "R5 popped", rspValid, 0);
    check(dbgClk == 1'b1, "R5 command not taken in pop cycle", dbgClk, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    check(dbgClk == 1'b0, "R2 command taken after pop", dbgClk, 0);
    check(dbgDataOut == 4'h5 && dbgDataOe, "R3 queued write data", dbgDataOut, 5);
    repeat (6) @(negedge clk);
    check(cmdReady == 1'b1 && rspValid == 1'b0, "R9 queued write done", cmdReady, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule